// File: doc/BRIEF.md
# Incremental ADC Cascaded CIC Decimator

This block turns the 3-bit code stream of an incremental sigma-delta modulator into one 13-bit conversion result for every 100 accepted input samples. Filtering runs in two cascaded cascaded-integrator-comb (CIC) sections. The first is fifth order and decimates by 20. The second is fourth order and decimates by 5, and it runs on the output words of the first.

An incremental converter restarts its modulator at the start of every conversion, so the filter restarts with it. A conversion-start strobe clears every integrator, comb delay and sample counter. Each result is therefore a fixed weighted sum of the samples of its own frame, including the start-up transient of the cascade, and nothing from earlier frames leaks in. The system drives the strobe together with the first sample of each frame. A strobe in the middle of a frame abandons that frame.

Top module: `incr_cic_decim`

## Requirements
- R1: `din` is a signed two's-complement code (-4..3) that is taken only in cycles where `din_valid` is 1. In other cycles its value has no effect on any later result, and the frame position does not advance.
- R2: `result_valid` is high for exactly one clock, in the cycle after the clock edge that accepts the 100th valid sample counted from the last strobe (or from reset). No other cycle has it high.
- R3: `result` equals bits [34:22] (floor truncation) of the 35-bit cascade output. That output is the frame filtered by five length-20 moving sums with zero history and sampled at sample indices 19, 39, 59, 79 and 99, then filtered by four length-5 moving sums with zero history and sampled at the fifth of those words.
- R4: `conv_start` clears all filter and counter state. A sample presented in the same cycle with `din_valid` high becomes sample 0 of the new frame. A strobe with `din_valid` low starts an empty frame.
- R5: A strobe part-way through a frame abandons that frame. No result is produced for the partial frame, and the next result depends only on samples taken after the strobe.
- R6: After reset `result` is 0 and `result_valid` is 0. `result` keeps its value between result pulses.
- R7: Idle cycles (`din_valid` low) inside a frame only stretch it. The result equals that of the same 100 samples presented without gaps.
- R8: A result does not depend on the data of any earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | input | 1 | Conversion-start strobe; clears state |
| din | input | 3 | Signed modulator code |
| din_valid | input | 1 | Qualifies `din` |
| result | output | 13 | Signed conversion result |
| result_valid | output | 1 | One-cycle result strobe |

## Verification
The expected values come from a direct convolution model of the two boxcar cascades. The cascade is driven with constant levels at both ends of the code range, with alternating codes that the sinc nulls suppress, with single impulses at early and middle positions that show the weighting of the transient, and with a ramp and a late step. Constants separate gain and truncation errors. Impulses and steps at different positions reveal a wrong order, ratio or comb alignment. Further frames carry idle gaps with garbage data, a strobe without a sample, and a strobe that abandons a half-done frame of full negative scale. These show that only accepted samples of the current frame count.

// File: rtl/icd_pkg.sv
// Shared defaults and width arithmetic for the incremental CIC decimator.
// Assumes ratio**order fits in 63 bits.
package icd_pkg;
    localparam int IN_W_DEF  = 3;
    localparam int OUT_W_DEF = 13;
    localparam int N1_DEF    = 5;
    localparam int R1_DEF    = 20;
    localparam int N2_DEF    = 4;
    localparam int R2_DEF    = 5;

    // Register growth of an order-n CIC decimating by r: ceil(n*log2(r)).
    function automatic int growth_bits(input int ratio, input int order);
        longint prod;
        prod = 1;
        for (int i = 0; i < order; i++) prod = prod * ratio;
        return $clog2(prod);
    endfunction
endpackage

// File: rtl/icd_cic_stage.sv
// One CIC decimation section with a synchronous clear.
// Integrators ripple within the cycle, so after k valid inputs integ[j]
// holds the (j+1)-fold running sum. Every RATIO-th valid input, the comb
// chain fires combinationally in that same cycle.
// Assumes RATIO >= 2 and W > IN_W. Arithmetic wraps modulo 2**W.
module icd_cic_stage #(
    parameter int ORDER = 5,
    parameter int RATIO = 20,
    parameter int IN_W  = 3,
    parameter int W     = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 in_valid,
    input  logic [IN_W-1:0]      in_data,
    output logic                 out_valid,
    output logic signed [W-1:0]  out_data
);
    localparam int            CW   = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic signed [W-1:0] integ_q [ORDER];
    logic signed [W-1:0] dly_q   [ORDER];
    logic signed [W-1:0] sum_d   [ORDER];
    logic signed [W-1:0] diff_d  [ORDER+1];
    logic signed [W-1:0] ext;
    logic [CW-1:0]       cnt_q, cnt_base;
    logic                emit;

    // Integrator ripple; a clear makes the running sums start from zero.
    always_comb begin
        ext      = {{(W-IN_W){in_data[IN_W-1]}}, in_data};
        sum_d[0] = (clr ? '0 : integ_q[0]) + ext;
        for (int k = 1; k < ORDER; k++)
            sum_d[k] = (clr ? '0 : integ_q[k]) + sum_d[k-1];
    end

    // Comb chain against the last decimated values.
    always_comb begin
        diff_d[0] = sum_d[ORDER-1];
        for (int k = 0; k < ORDER; k++)
            diff_d[k+1] = diff_d[k] - dly_q[k];
    end

    // Decimation phase: fire on the RATIO-th valid input of a group.
    always_comb begin
        cnt_base  = clr ? '0 : cnt_q;
        emit      = in_valid && (cnt_base == LAST);
        out_valid = emit;
        out_data  = diff_d[ORDER];
    end

    // State update: clear, accumulate, and capture comb delays on emit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int k = 0; k < ORDER; k++) begin
                integ_q[k] <= '0;
                dly_q[k]   <= '0;
            end
        end else begin
            if (clr || in_valid)
                for (int k = 0; k < ORDER; k++)
                    integ_q[k] <= in_valid ? sum_d[k] : '0;
            if (in_valid)
                cnt_q <= emit ? '0 : cnt_base + 1'b1;
            else if (clr)
                cnt_q <= '0;
            if (clr) begin
                for (int k = 0; k < ORDER; k++) dly_q[k] <= '0;
            end else if (emit) begin
                for (int k = 0; k < ORDER; k++) dly_q[k] <= diff_d[k];
            end
        end
    end
endmodule

// File: rtl/icd_result_reg.sv
// Output register: keeps the top OUT_W bits of the final CIC word
// (floor truncation) and raises a one-cycle valid flag.
// Assumes W > OUT_W. The strobe does not clear this register.
module icd_result_reg #(
    parameter int W     = 35,
    parameter int OUT_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    output logic [OUT_W-1:0]    result,
    output logic                result_valid
);
    localparam int DROP = W - OUT_W;

    logic drop_unused;
    assign drop_unused = ^in_data[DROP-1:0];

    // Capture the result and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= in_valid;
            if (in_valid) result <= in_data[W-1 -: OUT_W];
        end
    end
endmodule

// File: rtl/incr_cic_decim.sv
// Incremental-ADC decimator: a CIC of order N1 / ratio R1 feeding a CIC of
// order N2 / ratio R2, both cleared by conv_start.
// Assumes the strobe marks the first sample of each conversion frame.
module incr_cic_decim
    import icd_pkg::*;
#(
    parameter int IN_W  = IN_W_DEF,
    parameter int OUT_W = OUT_W_DEF,
    parameter int N1    = N1_DEF,
    parameter int R1    = R1_DEF,
    parameter int N2    = N2_DEF,
    parameter int R2    = R2_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic [IN_W-1:0]  din,
    input  logic             din_valid,
    output logic [OUT_W-1:0] result,
    output logic             result_valid
);
    localparam int W1 = IN_W + growth_bits(R1, N1);
    localparam int W2 = W1 + growth_bits(R2, N2);

    logic                 s1_valid, s2_valid;
    logic signed [W1-1:0] s1_data;
    logic signed [W2-1:0] s2_data;

    icd_cic_stage #(.ORDER(N1), .RATIO(R1), .IN_W(IN_W), .W(W1)) u_stage1 (
        .clk(clk), .rst_n(rst_n), .clr(conv_start),
        .in_valid(din_valid), .in_data(din),
        .out_valid(s1_valid), .out_data(s1_data)
    );

    icd_cic_stage #(.ORDER(N2), .RATIO(R2), .IN_W(W1), .W(W2)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .clr(conv_start),
        .in_valid(s1_valid), .in_data(s1_data),
        .out_valid(s2_valid), .out_data(s2_data)
    );

    icd_result_reg #(.W(W2), .OUT_W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s2_valid), .in_data(s2_data),
        .result(result), .result_valid(result_valid)
    );
endmodule

// File: rtl/icd_checker.sv
// Protocol checks for incr_cic_decim. An independent frame counter tracks
// accepted samples since the last strobe and predicts each result strobe.
module icd_checker #(
    parameter int FRAME = 100,
    parameter int OUT_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_start,
    input logic             din_valid,
    input logic [OUT_W-1:0] result,
    input logic             result_valid
);
    localparam int SW = $clog2(FRAME + 1);

    logic [SW-1:0] seen_q;
    logic          done_q;

    // Count valid samples in the current frame; flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            done_q <= 1'b0;
        end else if (conv_start) begin
            seen_q <= din_valid ? SW'(1) : '0;
            done_q <= 1'b0;
        end else begin
            done_q <= din_valid && (seen_q == SW'(FRAME - 1));
            if (din_valid)
                seen_q <= (seen_q == SW'(FRAME - 1)) ? '0 : seen_q + 1'b1;
        end
    end

    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid == done_q);
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !din_valid |=> !result_valid);
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !result_valid);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));
endmodule

bind incr_cic_decim icd_checker #(.FRAME(R1 * R2), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
    .din_valid(din_valid), .result(result), .result_valid(result_valid)
);

// File: tb/sim_incr_cic_decim.sv
// Bench for incr_cic_decim: a stimulus table walked by one loop, then
// directed reset, abort, strobe-without-sample and hold tests.
module sim_incr_cic_decim;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME = 100;
    localparam int BLK1  = 20;
    localparam int NVEC  = 10;
    // pattern, a, b, gap-every (0 = none)
    // patterns: 0 const a, 1 alternate a/b, 2 impulse a at b, 3 ramp, 4 step to a at b
    localparam int STIM [NVEC][4] = '{
        '{0,  3,  0, 0}, '{0, -4,  0, 0}, '{0,  0,  0, 0}, '{0,  1,  0, 3},
        '{1,  3, -3, 0}, '{1, -4,  3, 0}, '{2,  3,  0, 0}, '{2, -4, 50, 0},
        '{3,  0,  0, 0}, '{4,  2, 60, 7}
    };

    logic        clk = 0, rst_n = 0, conv_start = 0, din_valid = 0;
    logic [2:0]  din = '0;
    logic [12:0] result;
    logic        result_valid;
    int checks = 0, fails = 0, pulses = 0, exp_pulses = 0;
    bit finished = 0;

    incr_cic_decim u0 (.clk(clk), .rst_n(rst_n), .conv_start(conv_start),
        .din(din), .din_valid(din_valid), .result(result), .result_valid(result_valid));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (rst_n && result_valid) pulses++;

    function automatic int sample_val(int pat, int a, int b, int i);
        case (pat)
            0: return a;
            1: return (i % 2 == 0) ? a : b;
            2: return (i == b) ? a : 0;
            3: return (i % 8) - 4;
            default: return (i < b) ? 0 : a;
        endcase
    endfunction

    // Reference: boxcar cascades with zero history, then floor by 2**22.
    function automatic int ref_result(int pat, int a, int b);
        longint s [FRAME];
        longint t [FRAME];
        longint y [5];
        longint z [5];
        longint acc;
        for (int i = 0; i < FRAME; i++) s[i] = sample_val(pat, a, b, i);
        for (int p = 0; p < 5; p++) begin
            for (int n = 0; n < FRAME; n++) begin
                acc = 0;
                for (int k = 0; k < BLK1; k++) if (n - k >= 0) acc += s[n-k];
                t[n] = acc;
            end
            for (int n = 0; n < FRAME; n++) s[n] = t[n];
        end
        for (int j = 0; j < 5; j++) y[j] = s[BLK1*j + BLK1 - 1];
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 5; n++) begin
                acc = 0;
                for (int k = 0; k < 5; k++) if (n - k >= 0) acc += y[n-k];
                z[n] = acc;
            end
            for (int n = 0; n < 5; n++) y[n] = z[n];
        end
        return int'(y[4] >>> 22);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_frame(int pat, int a, int b, int gap, bit strobe, int nsamp);
        for (int i = 0; i < nsamp; i++) begin
            if (gap > 0 && i % gap == gap - 1) begin
                @(negedge clk); conv_start = 0; din_valid = 0; din = 3'b101;
            end
            @(negedge clk);
            conv_start = strobe && (i == 0);
            din_valid = 1;
            din = 3'(sample_val(pat, a, b, i));
        end
    endtask

    task automatic finish_frame(int expv, string req);
        @(negedge clk);
        conv_start = 0; din_valid = 0;
        exp_pulses++;
        check(result_valid == 1, "R2 pulse", result_valid, 1);
        check($signed(result) == expv, req, $signed(result), expv);
        @(negedge clk);
        check(result_valid == 0, "R2 single", result_valid, 0);
    endtask

    initial begin
        int held;
        repeat (3) @(negedge clk);
        check(result == 0, "R6 reset result", result, 0);
        check(result_valid == 0, "R6 reset valid", result_valid, 0);
        rst_n = 1;
        @(negedge clk);

        // Table walk: R3 cascade response, R7 gaps, R8 history independence
        for (int v = 0; v < NVEC; v++) begin
            drive_frame(STIM[v][0], STIM[v][1], STIM[v][2], STIM[v][3], 1, FRAME);
            finish_frame(ref_result(STIM[v][0], STIM[v][1], STIM[v][2]),
                         STIM[v][3] > 0 ? "R7 gapped frame" : "R3 frame value");
        end

        // R5: abort a half frame of -4, then a fresh frame of ones
        drive_frame(0, -4, 0, 0, 1, 50);
        drive_frame(0, 1, 0, 0, 1, FRAME);
        finish_frame(ref_result(0, 1, 0), "R5 abort");

        // R4: strobe with din_valid low, then 100 samples without strobe
        @(negedge clk); conv_start = 1; din_valid = 0; din = 3'b011;
        drive_frame(3, 0, 0, 0, 0, FRAME);
        finish_frame(ref_result(3, 0, 0), "R4 empty strobe");

        // R6/R1: idle garbage leaves result held and no pulse
        held = $signed(result);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); din_valid = 0; din = 3'(i);
            check(result_valid == 0, "R1 idle no pulse", result_valid, 0);
        end
        check($signed(result) == held, "R6 hold", $signed(result), held);

        // R8: same frame after a different previous frame
        drive_frame(2, 3, 0, 0, 1, FRAME);
        finish_frame(ref_result(2, 3, 0), "R8 no history");

        @(negedge clk);
        check(pulses == exp_pulses, "R2 pulse count", pulses, exp_pulses);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule